// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns eighteen asynchronous input lines into interrupt requests. Each line goes through a two-stage synchronizer. Edge detection then follows the line's rising-select and falling-select bits, so a line can trigger on a rising edge, a falling edge or either edge. A detected edge on an unmasked line sets that line's sticky pending flag. Software can also raise a line without any edge by writing its software-trigger bit.

Software reaches the controller through a simple single-cycle register bus. A write commits at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational from the address. Software acknowledges a request by writing 1 to the pending bit. That write also releases the line's software-trigger bit. Each line drives its own request output, which is its pending bit gated by its mask bit. A single combined request output is the OR of all line requests.

Register offsets: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14. In every register, bit n belongs to line n.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset, all six registers read 0, and `irq_line` and `irq_any` are 0.
- R2: The interrupt mask (0x00), event mask (0x04), rising select (0x08) and falling select (0x0C) registers read back bits 17:0 as written. Bits 31:18 of every register always read 0.
- R3: A rising edge on an input line sets the line's pending bit (0x14) when its rising-select and mask bits are both 1. The pending bit reads 1 after the third rising clock edge that follows the input change, and still reads 0 after the second.
- R4: A falling edge sets the pending bit when the line's falling-select and mask bits are both 1. With both select bits set, either edge sets it.
- R5: An edge never sets the pending bit of a line whose mask bit is 0, nor an edge whose select bit is 0.
- R6: Writing 1 to a software-trigger bit (0x10) that reads 0, on a line whose mask bit is 1, sets that line's pending bit at the same clock edge. The trigger bit then reads 1.
- R7: Writing 1 to a software-trigger bit that already reads 1 sets no pending bit. Writing 0 to a trigger bit leaves it unchanged. A 1 written on a line whose mask bit is 0 sets the trigger bit but not the pending bit.
- R8: Writing 1 to a pending bit clears both that pending bit and the line's software-trigger bit. Writing 0 to a pending bit has no effect.
- R9: When a set and a write-1 clear reach the same pending bit in the same clock cycle, the pending bit ends up 1.
- R10: `irq_line[n]` is 1 exactly when pending bit n and mask bit n are both 1. `irq_any` is 1 exactly when any `irq_line` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 18 | Asynchronous interrupt input lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_line | output | 18 | Per-line interrupt requests |
| irq_any | output | 1 | OR of all line requests |

## Verification
The synchronizer assertion assumes each input line changes at most once between clock edges. It also assumes the line does not change near an edge. The bench therefore drives the lines only at falling clock edges and holds them for several cycles. The bus assertions assume that one register access is presented per cycle with stable address and data. The bench drives every access at a falling edge, so it is captured whole at the next rising edge. To make the set-versus-clear collision happen, the bench times a pending-clear write to land on the exact cycle in which a synchronized edge reaches the pending logic.

// File: rtl/irq_line_pkg.sv
`timescale 1ns/1ps
package irq_line_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_EMASK = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_RISE  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FALL  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_SOFT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h14;

  typedef enum logic [2:0] {
    SEL_IMASK,
    SEL_EMASK,
    SEL_RISE,
    SEL_FALL,
    SEL_SOFT,
    SEL_PEND,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs)
      OFS_IMASK: sel = SEL_IMASK;
      OFS_EMASK: sel = SEL_EMASK;
      OFS_RISE:  sel = SEL_RISE;
      OFS_FALL:  sel = SEL_FALL;
      OFS_SOFT:  sel = SEL_SOFT;
      OFS_PEND:  sel = SEL_PEND;
      default:   sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/irq_line_sync.sv
`timescale 1ns/1ps
module irq_line_sync #(
  parameter int LINES = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_in,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  // stage 0/1 synchronize, stage 2 holds the previous synchronized level
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [2:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[1:0], line_in[i]};
    end

    assign rise_o[i] =  chain_q[1] & ~chain_q[2];
    assign fall_o[i] = ~chain_q[1] &  chain_q[2];
  end

  // a rising edge reported now reflects an input that was high two edges ago
  assert_rise_tracks_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & ~$past(line_in, 2)) == '0);

  assert_fall_tracks_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o & $past(line_in, 2)) == '0);

endmodule

// File: rtl/irq_line_regs.sv
`timescale 1ns/1ps
module irq_line_regs
  import irq_line_pkg::*;
#(
  parameter int LINES = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  soft_q,
  input  logic [LINES-1:0]  pend_q,
  output logic [LINES-1:0]  imask_q,
  output logic [LINES-1:0]  emask_q,
  output logic [LINES-1:0]  rise_sel_q,
  output logic [LINES-1:0]  fall_sel_q,
  output logic              soft_wr,
  output logic              pend_wr,
  output logic [LINES-1:0]  wdata_l
);

  localparam int PAD = DATA_W - LINES;

  reg_sel_e sel;
  logic     wr_strobe;
  logic     unused_wdata_hi;

  assign sel             = decode_offset(bus_addr);
  assign wr_strobe       = bus_sel & bus_wr;
  assign wdata_l         = bus_wdata[LINES-1:0];
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:LINES];

  assign soft_wr = wr_strobe && (sel == SEL_SOFT);
  assign pend_wr = wr_strobe && (sel == SEL_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imask_q    <= '0;
      emask_q    <= '0;
      rise_sel_q <= '0;
      fall_sel_q <= '0;
    end else if (wr_strobe) begin
      case (sel)
        SEL_IMASK: imask_q    <= wdata_l;
        SEL_EMASK: emask_q    <= wdata_l;
        SEL_RISE:  rise_sel_q <= wdata_l;
        SEL_FALL:  fall_sel_q <= wdata_l;
        default: ;
      endcase
    end
  end

  logic [LINES-1:0] rd_l;

  always_comb begin
    case (sel)
      SEL_IMASK: rd_l = imask_q;
      SEL_EMASK: rd_l = emask_q;
      SEL_RISE:  rd_l = rise_sel_q;
      SEL_FALL:  rd_l = fall_sel_q;
      SEL_SOFT:  rd_l = soft_q;
      SEL_PEND:  rd_l = pend_q;
      default:   rd_l = '0;
    endcase
  end

  assign bus_rdata = {{PAD{1'b0}}, rd_l};

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:LINES] == '0);

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(soft_wr && pend_wr));

  assert_mask_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && bus_addr == OFS_IMASK) |=> imask_q == $past(bus_wdata[LINES-1:0]));

endmodule

// File: rtl/irq_line_pend.sv
`timescale 1ns/1ps
module irq_line_pend #(
  parameter int LINES = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] rise_i,
  input  logic [LINES-1:0] fall_i,
  input  logic [LINES-1:0] imask_i,
  input  logic [LINES-1:0] rise_sel_i,
  input  logic [LINES-1:0] fall_sel_i,
  input  logic             soft_wr,
  input  logic             pend_wr,
  input  logic [LINES-1:0] wdata_l,
  output logic [LINES-1:0] soft_q,
  output logic [LINES-1:0] pend_q,
  output logic [LINES-1:0] hw_set,
  output logic [LINES-1:0] sw_set,
  output logic [LINES-1:0] clr_vec
);

  function automatic logic [LINES-1:0] edge_hits(
    input logic [LINES-1:0] r, input logic [LINES-1:0] f,
    input logic [LINES-1:0] rs, input logic [LINES-1:0] fs,
    input logic [LINES-1:0] m);
    return ((r & rs) | (f & fs)) & m;
  endfunction

  // only a 0-to-1 transition of the trigger bit on an unmasked line fires
  function automatic logic [LINES-1:0] soft_fires(
    input logic [LINES-1:0] w, input logic [LINES-1:0] cur,
    input logic [LINES-1:0] m);
    return w & ~cur & m;
  endfunction

  // set beats clear
  function automatic logic [LINES-1:0] pend_update(
    input logic [LINES-1:0] p, input logic [LINES-1:0] s,
    input logic [LINES-1:0] c);
    return (p & ~c) | s;
  endfunction

  logic [LINES-1:0] set_vec;

  assign hw_set  = edge_hits(rise_i, fall_i, rise_sel_i, fall_sel_i, imask_i);
  assign sw_set  = soft_wr ? soft_fires(wdata_l, soft_q, imask_i) : '0;
  assign clr_vec = pend_wr ? wdata_l : '0;
  assign set_vec = hw_set | sw_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      soft_q <= '0;
    end else begin
      pend_q <= pend_update(pend_q, set_vec, clr_vec);
      if (soft_wr)      soft_q <= soft_q | wdata_l;
      else if (pend_wr) soft_q <= soft_q & ~wdata_l;
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & clr_vec)) |=> (pend_q & $past(set_vec)) == $past(set_vec));

  assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> (pend_q & $past(clr_vec & ~set_vec)) == '0);

  assert_soft_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> (soft_q & $past(clr_vec)) == '0);

  assert_no_spurious_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0);

  assert_masked_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec & ~imask_i) == '0);

  assert_soft_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> (soft_q & $past(soft_q)) == $past(soft_q));

endmodule

// File: rtl/irq_line_ctrl.sv
`timescale 1ns/1ps
module irq_line_ctrl
  import irq_line_pkg::*;
#(
  parameter int LINES = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [LINES-1:0]  irq_line,
  output logic              irq_any
);

  logic [LINES-1:0] rise, fall;
  logic [LINES-1:0] imask_q, emask_q, rise_sel_q, fall_sel_q;
  logic [LINES-1:0] soft_q, pend_q, wdata_l;
  logic [LINES-1:0] hw_set, sw_set, clr_vec;
  logic             soft_wr, pend_wr;
  logic             unused_emask;

  irq_line_sync #(.LINES(LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_in(line_in),
    .rise_o (rise),
    .fall_o (fall)
  );

  irq_line_regs #(.LINES(LINES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .soft_q    (soft_q),
    .pend_q    (pend_q),
    .imask_q   (imask_q),
    .emask_q   (emask_q),
    .rise_sel_q(rise_sel_q),
    .fall_sel_q(fall_sel_q),
    .soft_wr   (soft_wr),
    .pend_wr   (pend_wr),
    .wdata_l   (wdata_l)
  );

  irq_line_pend #(.LINES(LINES)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_i    (rise),
    .fall_i    (fall),
    .imask_i   (imask_q),
    .rise_sel_i(rise_sel_q),
    .fall_sel_i(fall_sel_q),
    .soft_wr   (soft_wr),
    .pend_wr   (pend_wr),
    .wdata_l   (wdata_l),
    .soft_q    (soft_q),
    .pend_q    (pend_q),
    .hw_set    (hw_set),
    .sw_set    (sw_set),
    .clr_vec   (clr_vec)
  );

  // event mask is storage only here
  assign unused_emask = ^emask_q;

  assign irq_line = pend_q & imask_q;
  assign irq_any  = |irq_line;

  // a request newly raised must come from a set in the previous cycle or an unmask
  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line & ~$past(irq_line) & ~$past(hw_set | sw_set) & $past(imask_q)) == '0);

  assert_irq_any_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_any) |-> $countones(irq_line) >= 1);

endmodule

// File: tb/irq_line_ctrl_test.sv
`timescale 1ns/1ps
module irq_line_ctrl_test;

  localparam int L = 18;
  localparam logic [7:0] A_IM = 8'h00, A_EM = 8'h04, A_RS = 8'h08,
                         A_FS = 8'h0C, A_SW = 8'h10, A_PD = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [L-1:0] line_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [L-1:0] irq_line;
  logic        irq_any;

  int checks = 0;
  int errors = 0;

  logic [L-1:0] m_im = '0, m_em = '0, m_rs = '0, m_fs = '0, m_sw = '0, m_pd = '0, m_line = '0;

  irq_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_line(irq_line), .irq_any(irq_any)
  );

  always #2.5 clk = ~clk;

  // ---- reference model, written bit by bit ----
  function automatic logic [L-1:0] mdl_edges(input logic [L-1:0] o, input logic [L-1:0] n);
    logic [L-1:0] r = '0;
    for (int i = 0; i < L; i++) begin
      if (m_im[i] && ((!o[i] && n[i] && m_rs[i]) || (o[i] && !n[i] && m_fs[i]))) r[i] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [L-1:0] mdl_soft(input logic [L-1:0] w);
    logic [L-1:0] r = '0;
    for (int i = 0; i < L; i++) begin
      if (w[i] && !m_sw[i] && m_im[i]) r[i] = 1'b1;
    end
    return r;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    logic [L-1:0] dl = d[L-1:0];
    case (a)
      A_IM: m_im = dl;
      A_EM: m_em = dl;
      A_RS: m_rs = dl;
      A_FS: m_fs = dl;
      A_SW: begin m_pd = m_pd | mdl_soft(dl); m_sw = m_sw | dl; end
      A_PD: begin m_pd = m_pd & ~dl; m_sw = m_sw & ~dl; end
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    bus_read(A_IM, d); check({tag, " R2 imask"}, d, {14'd0, m_im});
    bus_read(A_EM, d); check({tag, " R2 emask"}, d, {14'd0, m_em});
    bus_read(A_RS, d); check({tag, " R2 rise"},  d, {14'd0, m_rs});
    bus_read(A_FS, d); check({tag, " R2 fall"},  d, {14'd0, m_fs});
    bus_read(A_SW, d); check({tag, " R7 soft"},  d, {14'd0, m_sw});
    bus_read(A_PD, d); check({tag, " R8 pend"},  d, {14'd0, m_pd});
    check({tag, " R10 irq_line"}, {14'd0, irq_line}, {14'd0, m_pd & m_im});
    check({tag, " R10 irq_any"}, {31'd0, irq_any}, {31'd0, |(m_pd & m_im)});
  endtask

  task automatic drive_lines(input logic [L-1:0] v);
    @(negedge clk);
    line_in = v;
    repeat (4) @(negedge clk);
    m_pd = m_pd | mdl_edges(m_line, v);
    m_line = v;
  endtask

  logic done = 1'b0;

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_all("R1 reset");

    // R2: all-ones write, reserved bits drop
    bus_write(A_IM, 32'hFFFF_FFFF);
    bus_write(A_EM, 32'hFFFF_FFFF);
    bus_write(A_RS, 32'hFFFF_FFFF);
    bus_write(A_FS, 32'h0000_0000);
    check_all("R2 ones");
    bus_write(A_EM, 32'h0001_2345);
    bus_write(A_RS, 32'h0000_0001);
    check_all("R2 pattern");

    // R3: exact latency of a rising edge on line 0
    @(negedge clk);
    line_in[0] = 1'b1; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_PD;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R3 pend after two edges", bus_rdata, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R3 pend after three edges", bus_rdata, 32'd1);
    bus_sel = 1'b0;
    m_line[0] = 1'b1; m_pd[0] = 1'b1;
    check_all("R3 rise");

    // R4: falling only on line 1, both edges on line 2
    bus_write(A_FS, 32'h0000_0006);
    bus_write(A_RS, 32'h0000_0005);
    drive_lines(18'h00006);           // line1 rise (no rise sel), line2 rise
    check("R4 rise on both-edge line", {14'd0, m_pd}, 32'h0000_0005);
    check_all("R4 after rise");
    drive_lines(18'h00000);           // line1 and line2 fall
    check_all("R4 after fall");

    // R5: masked line and unselected edge
    bus_write(A_PD, 32'h0003_FFFF);
    bus_write(A_IM, 32'h0000_0000);
    bus_write(A_RS, 32'h0003_FFFF);
    drive_lines(18'h000F0);
    check_all("R5 masked");
    bus_write(A_IM, 32'h0003_FFFF);
    bus_write(A_RS, 32'h0000_0000);
    bus_write(A_FS, 32'h0000_0000);
    drive_lines(18'h00000);
    check_all("R5 unselected");

    // R6: software trigger on line 9
    bus_write(A_SW, 32'h0000_0200);
    check_all("R6 soft set");
    // R7: repeat, zero write, masked soft
    bus_write(A_PD, 32'h0000_0000);   // R8 write 0 no effect
    check_all("R8 zero write");
    bus_write(A_IM, 32'h0003_F7FF);   // line 11 masked
    bus_write(A_SW, 32'h0000_0A00);   // line 9 already set, line 11 masked
    check_all("R7 repeat and masked");
    bus_write(A_SW, 32'h0000_0000);
    check_all("R7 zero keeps");
    // R8: clear pending 9 releases soft 9, then soft refires
    bus_write(A_PD, 32'h0000_0A00);
    check_all("R8 clear");
    bus_write(A_SW, 32'h0000_0200);
    check_all("R8 refire");

    // R9: hardware set lands on the same edge as a clear
    bus_write(A_RS, 32'h0000_0020);
    bus_write(A_SW, 32'h0000_0020);
    @(negedge clk);
    line_in[5] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_PD; bus_wdata = 32'h0000_0020;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    m_sw[5] = 1'b0; m_line[5] = 1'b1;
    check_all("R9 set wins");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [31:0] r;
      op = $urandom_range(0, 7);
      r  = $urandom;
      case (op)
        0: bus_write(A_IM, r);
        1: bus_write(A_EM, r);
        2: bus_write(A_RS, r);
        3: bus_write(A_FS, r);
        4: bus_write(A_SW, r & 32'h0000_0F0F);
        5: bus_write(A_PD, r);
        default: drive_lines(r[L-1:0]);
      endcase
      check_all("rand R3 R4 R6");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule